// File: doc/BRIEF.md
# Bus Clock Prescaler with Gating

This block derives clock-enable strobes for four bus domains from a single main clock: the processor domain, the high-speed system bus, and two peripheral buses (A and B). Each domain owns a power-of-two prescaler, configured by a 4-bit field in one shared select register. Each domain also owns a mask register with one bit per attached module. The per-module enable is the domain strobe gated by that module's mask bit. Logic downstream qualifies its flops with these enables instead of receiving divided clocks.

Software programs the block through a simple 32-bit request/response port. Mask registers read back exactly what was written, so drivers can change a single module's clock with a read-modify-write. A change of divide ratio is held back until the domain finishes its current strobe period, so no strobe period is ever cut short. A separate keep-alive strobe follows the peripheral bus B domain and ignores its mask. This keeps the system-control modules on that bus running.

Top module: `busclk_gate`

## Requirements
- R1: After reset the select register reads 0 and every mask register reads all ones in its low MOD_W bits. Every domain strobe and every module enable is high in each cycle until software changes the configuration.
- R2: When a domain's divide-enable bit is 0, that domain's strobe is high in every cycle, whatever its 3-bit select field holds.
- R3: When a domain's divide-enable bit is 1, the domain strobe is high once every 2^(sel+1) cycles. Register 0x04 holds the fields as follows. Processor: sel in bits 2:0, enable in bit 7. High-speed bus: sel in bits 10:8, enable in bit 15. Peripheral bus A: sel in bits 18:16, enable in bit 23. Peripheral bus B: sel in bits 26:24, enable in bit 31.
- R4: Each domain's prescaler depends only on its own field. Rewriting one field leaves the strobe period of every other domain unchanged.
- R5: A new select value is taken up at the domain's next strobe. The period already in progress completes at its old length, and the new ratio applies from the following period.
- R6: Module enable mod_ce[d*MOD_W+i] is high exactly when dom_ce[d] is high and bit i of domain d's mask is 1. Domains are indexed 0 to 3 in the order processor, high-speed, peripheral A, peripheral B.
- R7: The mask registers for domains 0 to 3 sit at offsets 0x08, 0x0C, 0x10 and 0x14. Each reads back exactly the low MOD_W bits last written to it, and the bits above MOD_W read 0.
- R8: keep_alive_ce equals the peripheral bus B strobe dom_ce[3] in every cycle, even when the peripheral bus B mask is all zeros.
- R9: A read request gives rsp_valid high, with the read data, in exactly the next cycle. A write request produces no response.
- R10: Writes to offsets other than 0x04 and 0x08 to 0x14 change no register, and reads of those offsets return 0. Bits of the select register outside the sel and enable fields read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| dom_ce | output | 4 | Domain strobes: processor, high-speed, peripheral A, peripheral B |
| mod_ce | output | 4*MOD_W | Per-module enables, MOD_W bits per domain |
| keep_alive_ce | output | 1 | Always-running strobe of peripheral bus B |

## Verification
The hardest case to reach is a ratio change that arrives in the middle of a long prescaler period. If that happens, a faulty design would emit a short period that only shows as one wrong gap between two strobes. The stimulus sets peripheral bus A to divide by 256 and waits for one of its strobes. Ten cycles later it rewrites the field to divide by 2. It then counts the cycles to the next strobe, which must still be 256, and after that it checks that the following gap is 2. Field independence and gating are covered with mixed ratios, which include a select field that is non-zero while its divide enable is clear.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

    localparam int NDOM      = 4;
    localparam int DATA_W    = 32;
    localparam int SEL_W     = 3;
    localparam int FIELD_W   = 8;
    localparam int DIVEN_POS = 7;
    localparam int CNT_W     = 2 ** SEL_W;

    localparam logic [7:0] OFF_SEL       = 8'h04;
    localparam logic [7:0] OFF_MASK_BASE = 8'h08;

    typedef enum logic [1:0] {
        D_CPU = 2'd0,
        D_HSB = 2'd1,
        D_PBA = 2'd2,
        D_PBB = 2'd3
    } dom_id_t;

    typedef struct packed {
        logic             div_en;
        logic [SEL_W-1:0] sel;
    } dom_cfg_t;

    function automatic dom_cfg_t field_of(input logic [DATA_W-1:0] r, input int d);
        dom_cfg_t c;
        c.div_en = r[d*FIELD_W + DIVEN_POS];
        c.sel    = r[d*FIELD_W +: SEL_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] sel_keep();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int d = 0; d < NDOM; d++) begin
            m[d*FIELD_W +: SEL_W]      = '1;
            m[d*FIELD_W + DIVEN_POS]   = 1'b1;
        end
        return m;
    endfunction

    // Terminal count of a 2^(sel+1) period: all ones in the low sel+1 bits.
    function automatic logic [CNT_W-1:0] last_count(input logic [SEL_W-1:0] s);
        return {CNT_W{1'b1}} >> (CNT_W - 1 - int'(s));
    endfunction

endpackage

// File: rtl/busclk_regs.sv
module busclk_regs
    import busclk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int MOD_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_rdata,
    output logic [DATA_W-1:0]             sel_q,
    output logic [NDOM-1:0][MOD_W-1:0]    mask_q
);

    localparam logic [DATA_W-1:0] SEL_KEEP = sel_keep();

    logic              wr_en;
    logic              rd_en;
    logic              hit_sel;
    logic [NDOM-1:0]   hit_mask;
    logic [DATA_W-1:0] rd_next;

    assign wr_en   = req_valid && req_write;
    assign rd_en   = req_valid && !req_write;
    assign hit_sel = (req_addr == ADDR_W'(OFF_SEL));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr_en && hit_sel) begin
            sel_q <= req_wdata & SEL_KEEP;
        end
    end

    for (genvar d = 0; d < NDOM; d++) begin : g_mask
        assign hit_mask[d] = (req_addr == ADDR_W'(OFF_MASK_BASE + 8'(4 * d)));

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[d] <= '1;
            end else if (wr_en && hit_mask[d]) begin
                mask_q[d] <= req_wdata[MOD_W-1:0];
            end
        end
    end

    always_comb begin
        rd_next = '0;
        if (hit_sel) begin
            rd_next = sel_q;
        end
        for (int d = 0; d < NDOM; d++) begin
            if (hit_mask[d]) begin
                rd_next = DATA_W'(mask_q[d]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) begin
                rsp_rdata <= rd_next;
            end
        end
    end

endmodule

// File: rtl/busclk_div.sv
module busclk_div
    import busclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dom_cfg_t cfg_i,
    output logic     ce_o
);

    dom_cfg_t         act_q;
    logic [CNT_W-1:0] cnt_q;

    // A strobe marks a period boundary; the requested config is adopted only there.
    assign ce_o = !act_q.div_en || (cnt_q == last_count(act_q.sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            cnt_q <= '0;
        end else if (ce_o) begin
            act_q <= cfg_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/busclk_gate.sv
module busclk_gate
    import busclk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int MOD_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic [NDOM-1:0]         dom_ce,
    output logic [NDOM*MOD_W-1:0]   mod_ce,
    output logic                    keep_alive_ce
);

    logic [DATA_W-1:0]          sel_q;
    logic [NDOM-1:0][MOD_W-1:0] mask_q;
    dom_cfg_t                   cfg [NDOM];

    busclk_regs #(
        .ADDR_W (ADDR_W),
        .MOD_W  (MOD_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .sel_q     (sel_q),
        .mask_q    (mask_q)
    );

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        assign cfg[d] = field_of(sel_q, d);

        busclk_div u_div (
            .clk   (clk),
            .rst   (rst),
            .cfg_i (cfg[d]),
            .ce_o  (dom_ce[d])
        );

        assign mod_ce[d*MOD_W +: MOD_W] = {MOD_W{dom_ce[d]}} & mask_q[d];
    end

    assign keep_alive_ce = dom_ce[D_PBB];

endmodule

// File: rtl/busclk_gate_chk.sv
module busclk_gate_chk
    import busclk_pkg::*;
#(
    parameter int MOD_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_write,
    input logic                  rsp_valid,
    input logic [NDOM-1:0]       dom_ce,
    input logic [NDOM*MOD_W-1:0] mod_ce
);

    localparam int GAP_LIM = 2 ** CNT_W;

    logic [CNT_W:0] gap_q [NDOM];

    AST_RESET_ALL_RUN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&dom_ce)); // R1

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid); // R9

    AST_RSP_ONLY_FOR_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write)); // R9

    for (genvar d = 0; d < NDOM; d++) begin : g_chk
        always_ff @(posedge clk) begin
            if (rst || dom_ce[d]) begin
                gap_q[d] <= '0;
            end else if (gap_q[d] != '1) begin
                gap_q[d] <= gap_q[d] + 1'b1;
            end
        end

        AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (rst)
            gap_q[d] <= (CNT_W+1)'(GAP_LIM - 1)); // R3

        AST_MOD_GATED: assert property (@(posedge clk) disable iff (rst)
            (|mod_ce[d*MOD_W +: MOD_W]) |-> dom_ce[d]); // R6
    end

endmodule

bind busclk_gate busclk_gate_chk #(.MOD_W(MOD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .dom_ce    (dom_ce),
    .mod_ce    (mod_ce)
);

// File: tb/busclk_gate_bench.sv
module busclk_gate_bench;
    import busclk_pkg::*;

    localparam int ADDR_W = 8;
    localparam int MOD_W  = 16;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  req_valid;
    logic                  req_write;
    logic [ADDR_W-1:0]     req_addr;
    logic [DATA_W-1:0]     req_wdata;
    logic                  rsp_valid;
    logic [DATA_W-1:0]     rsp_rdata;
    logic [NDOM-1:0]       dom_ce;
    logic [NDOM*MOD_W-1:0] mod_ce;
    logic                  keep_alive_ce;

    busclk_gate #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) u_busclk_gate (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .dom_ce        (dom_ce),
        .mod_ce        (mod_ce),
        .keep_alive_ce (keep_alive_ce)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q [$];
    int          cyc_q [$];
    string       tag_q [$];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(e);
        cyc_q.push_back(cyc + 1);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_ce(input int d);
        do @(negedge clk); while (!dom_ce[d]);
    endtask

    task automatic measure_gap(input int d, output int g);
        int t0;
        wait_ce(d);
        t0 = cyc;
        wait_ce(d);
        g = cyc - t0;
    endtask

    // Scoreboard monitor: pops expected read data as responses appear.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 response without read", 1, 0);
            end else begin
                logic [31:0] e;
                int          c;
                string       t;
                e = exp_q.pop_front();
                c = cyc_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_rdata == e, t, rsp_rdata, e);
                check(cyc == c, {t, " / R9 latency"}, cyc, c);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        int g;
        int t0;
        int pulses;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check(dom_ce == 4'hF, "R1 strobes after reset", dom_ce, 4'hF);
        check(mod_ce == '1, "R1 module enables after reset", mod_ce, 64'hFFFF_FFFF_FFFF_FFFF);
        do_read(8'h04, 32'h0, "R1 select reset");
        for (int d = 0; d < NDOM; d++) do_read(8'(8 + 4*d), 32'h0000_FFFF, "R1 mask reset");
        measure_gap(1, g);
        check(g == 1, "R2 bypass after reset", g, 1);

        // R3 / R4 / R2: mixed ratios, HSB sel=5 with divide disabled
        do_write(8'h04, 32'h8182_0580);
        do_read(8'h04, 32'h8182_0580, "R3 select readback");
        repeat (20) @(negedge clk);
        measure_gap(0, g); check(g == 2, "R3 CPU divide by 2", g, 2);
        measure_gap(1, g); check(g == 1, "R2 HSB bypass with sel=5", g, 1);
        measure_gap(2, g); check(g == 8, "R3 PBA divide by 8", g, 8);
        measure_gap(3, g); check(g == 4, "R3 PBB divide by 4", g, 4);

        // R4: change CPU only
        do_write(8'h04, 32'h8182_0583);
        repeat (40) @(negedge clk);
        measure_gap(0, g); check(g == 16, "R4 CPU now divide by 16", g, 16);
        measure_gap(2, g); check(g == 8, "R4 PBA unchanged", g, 8);
        measure_gap(3, g); check(g == 4, "R4 PBB unchanged", g, 4);

        // R6: CPU mask gating
        do_write(8'h08, 32'h0000_00A5);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            check(mod_ce[15:0] == (dom_ce[0] ? 16'h00A5 : 16'h0), "R6 CPU gated enables",
                  mod_ce[15:0], dom_ce[0] ? 16'h00A5 : 16'h0);
            check(mod_ce[31:16] == 16'hFFFF, "R6 HSB full mask", mod_ce[31:16], 16'hFFFF);
        end

        // R8: keep-alive ignores PBB mask
        do_write(8'h14, 32'h0);
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (keep_alive_ce) pulses++;
            check(keep_alive_ce == dom_ce[3], "R8 keep-alive follows PBB", keep_alive_ce, dom_ce[3]);
            check(mod_ce[63:48] == 16'h0, "R8 PBB modules gated off", mod_ce[63:48], 0);
        end
        check(pulses == 5, "R8 keep-alive pulse count", pulses, 5);

        // R5: ratio change in the middle of a long period
        do_write(8'h04, 32'h8187_0583);
        repeat (600) @(negedge clk);
        measure_gap(2, g); check(g == 256, "R3 PBA divide by 256", g, 256);
        wait_ce(2);
        t0 = cyc;
        repeat (10) @(negedge clk);
        do_write(8'h04, 32'h8180_0583);
        wait_ce(2);
        check(cyc - t0 == 256, "R5 period in progress kept", cyc - t0, 256);
        measure_gap(2, g); check(g == 2, "R5 new ratio after boundary", g, 2);

        // R7: mask readback and read-modify-write
        do_write(8'h08, 32'hFFFF_5A3C);
        do_write(8'h0C, 32'h0000_0001);
        do_write(8'h10, 32'h0000_8000);
        do_write(8'h14, 32'h0000_FFFF);
        do_read(8'h08, 32'h0000_5A3C, "R7 CPU mask upper bits dropped");
        do_read(8'h0C, 32'h0000_0001, "R7 HSB mask");
        do_read(8'h10, 32'h0000_8000, "R7 PBA mask");
        do_read(8'h14, 32'h0000_FFFF, "R7 PBB mask");
        do_write(8'h08, 32'h0000_5A3C | 32'h0000_0100);
        do_read(8'h08, 32'h0000_5B3C, "R7 read-modify-write");

        // R10: undefined offsets and reserved select bits
        do_write(8'h00, 32'h0);
        do_write(8'h18, 32'h0);
        do_write(8'h40, 32'hFFFF_FFFF);
        do_read(8'h00, 32'h0, "R10 undefined offset 0x00 reads 0");
        do_read(8'h18, 32'h0, "R10 undefined offset 0x18 reads 0");
        do_read(8'h04, 32'h8180_0583, "R10 select untouched");
        do_read(8'h08, 32'h0000_5B3C, "R10 mask untouched");
        do_write(8'h04, 32'hFFFF_FFFF);
        do_read(8'h04, 32'h8787_8787, "R10 reserved select bits read 0");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 missing responses", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule